// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register Interface

This block is the byte-wide host register front end of a 48-line digital I/O chip. Each line can be used as an open-drain output or as an input. Six port registers hold the output latches. A set bit makes the pin sink current. A clear bit leaves the pin released, and an external pull-up then holds it high. A read of a port returns the synchronized pin level inverted, so a released, pulled-up pin reads as 0 and a pin held low reads as 1.

A control register at offset 0x07 holds two fields. The upper two bits select a page. The lower six bits are per-port write locks. Offsets 0x08 to 0x0A form a three-byte window whose meaning depends on the page:

| Page | Window contents |
|------|-----------------|
| 1 | edge polarity bytes |
| 2 | edge enable bytes |
| 3 | interrupt-ID bytes |
| 0 | unused |

The polarity and enable bytes are held here and passed on to the edge-detection block. The interrupt-ID bytes are read from that block, and a host write to them produces a per-byte clear strobe. Offset 0x06 returns the pending summary from the edge block. The whole chip takes a 16-byte address window.

Top module: `gpio_pg_regif`

## Requirements
- R1: After reset every pin_oe_o bit is 0, so all pins are released. The control register reads 0x00, and pol_o and enab_o are 0.
- R2: A write of byte D to port offset k (0 to 5) sets pin_oe_o[8k+7:8k] to D on the next clock edge. A 1 makes the pin sink, and a 0 releases it.
- R3: A read of port offset k returns the bitwise inverse of the synchronized pin_i[8k+7:8k], so a high pin reads 0.
- R4: A change on pin_i reaches the read data through two flip-flops. Counting from the edge after the change, the read data still shows the old value after the first clock edge and shows the new value after the second.
- R5: Offset 0x07 holds a page field in bits 7:6 and lock bits in bits 5:0, where bit k locks port k. A write is read back unchanged.
- R6: While lock bit k is set, writes to port k are ignored: pin_oe_o for that port and its readback keep their values. Other ports still take writes.
- R7: Offsets 0x08 to 0x0A access byte 0 to 2 of the bank chosen by the page field: 1 is polarity (pol_o), 2 is enable (enab_o), 3 is interrupt ID. A write changes only the selected bank, and a read returns that bank's byte.
- R8: On page 3, a read of window byte b returns int_id_i[8b+7:8b]. A write to byte b raises int_id_clr_o[b] in the same cycle as wr_en_i and raises no other bit. No strobe is raised on any other page.
- R9: On page 0 the window offsets read 0x00. Offsets 0x0B to 0x0F read 0x00 on every page. Writes to any of these change no register.
- R10: Offset 0x06 returns int_pend_i on every page. The port offsets work the same whatever page is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register offset within the 16-byte window |
| wr_en_i | input | 1 | Write strobe, taken on the rising clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pin_i | input | 48 | Pin levels as seen on the board |
| pin_oe_o | output | 48 | Per-line sink enable; 1 pulls the pin low |
| int_pend_i | input | 8 | Pending summary from the edge block |
| int_id_i | input | 24 | Interrupt-ID bytes from the edge block |
| int_id_clr_o | output | 3 | Per-byte write strobe for the interrupt-ID bank |
| pol_o | output | 24 | Edge polarity bytes |
| enab_o | output | 24 | Edge enable bytes |

## Verification
Port data patterns such as 0xA5, 0x3C and 0x0F use mixed bit values, so a swapped bit or a missing inversion shows up in the readback. Reading back through pulled-up pins shows that a sinking line reads 1. A separate pattern drives pins low from outside while the latch is clear, which separates the inversion of the pin from an echo of the latch. The window is written on one page and then read on the other pages, which shows whether the banks are steered apart. Writes made while a port is locked, and writes on page 0 and to the unused offsets, are each followed by a read of the register they could have changed.

// File: rtl/gpio_pg_pkg.sv
package gpio_pg_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    PG_NONE  = 2'd0,
    PG_POL   = 2'd1,
    PG_ENAB  = 2'd2,
    PG_IRQID = 2'd3
  } page_e;
endpackage

// File: rtl/gpio_pg_sync.sv
module gpio_pg_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pg_ports.sv
module gpio_pg_ports #(
  parameter int NUM_PORTS = 6,
  localparam int BW = gpio_pg_pkg::BYTE_W,
  localparam int LINES = NUM_PORTS * BW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] we_i,
  input  logic [NUM_PORTS-1:0] lock_i,
  input  logic [BW-1:0]        wdata_i,
  output logic [LINES-1:0]     latch_o
);
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    logic [BW-1:0] lat_q;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                   lat_q <= '0;
      else if (we_i[k] && !lock_i[k]) lat_q <= wdata_i;

    assign latch_o[k*BW +: BW] = lat_q;

    assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[k] && lock_i[k]) |=> $stable(latch_o[k*BW +: BW]));

    assert_port_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i[k] && !lock_i[k]) |=> (latch_o[k*BW +: BW] == $past(wdata_i)));
  end
endmodule

// File: rtl/gpio_pg_paged.sv
module gpio_pg_paged #(
  parameter int NUM_PORTS = 6,
  parameter int WIN_BYTES = 3,
  localparam int BW = gpio_pg_pkg::BYTE_W,
  localparam int WIN_W = WIN_BYTES * BW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ctl_we_i,
  input  logic [WIN_BYTES-1:0] pol_we_i,
  input  logic [WIN_BYTES-1:0] enab_we_i,
  input  logic [BW-1:0]        wdata_i,
  output gpio_pg_pkg::page_e   page_o,
  output logic [NUM_PORTS-1:0] lock_o,
  output logic [WIN_W-1:0]     pol_o,
  output logic [WIN_W-1:0]     enab_o
);
  import gpio_pg_pkg::*;

  page_e                page_q;
  logic [NUM_PORTS-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      page_q <= PG_NONE;
      lock_q <= '0;
    end else if (ctl_we_i) begin
      page_q <= page_e'(wdata_i[BW-1 -: 2]);
      lock_q <= wdata_i[NUM_PORTS-1:0];
    end

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_win
    logic [BW-1:0] pol_q, enab_q;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        pol_q  <= '0;
        enab_q <= '0;
      end else begin
        if (pol_we_i[b])  pol_q  <= wdata_i;
        if (enab_we_i[b]) enab_q <= wdata_i;
      end
    assign pol_o[b*BW +: BW]  = pol_q;
    assign enab_o[b*BW +: BW] = enab_q;
  end

  assign page_o = page_q;
  assign lock_o = lock_q;

  assert_pol_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_we_i != '0) |=> $stable(enab_o));
  assert_enab_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enab_we_i != '0) |=> $stable(pol_o));
endmodule

// File: rtl/gpio_pg_regif.sv
module gpio_pg_regif #(
  parameter int NUM_PORTS   = 6,
  parameter int WIN_BYTES   = 3,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int BW         = gpio_pg_pkg::BYTE_W,
  localparam int LINES      = NUM_PORTS * BW,
  localparam int WIN_W      = WIN_BYTES * BW,
  localparam int PEND_OFF   = NUM_PORTS,
  localparam int CTL_OFF    = NUM_PORTS + 1,
  localparam int WIN_OFF    = NUM_PORTS + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [BW-1:0]        wdata_i,
  output logic [BW-1:0]        rdata_o,
  input  logic [LINES-1:0]     pin_i,
  output logic [LINES-1:0]     pin_oe_o,
  input  logic [BW-1:0]        int_pend_i,
  input  logic [WIN_W-1:0]     int_id_i,
  output logic [WIN_BYTES-1:0] int_id_clr_o,
  output logic [WIN_W-1:0]     pol_o,
  output logic [WIN_W-1:0]     enab_o
);
  import gpio_pg_pkg::*;

  page_e                page;
  logic [NUM_PORTS-1:0] lock;
  logic [NUM_PORTS-1:0] port_we;
  logic [WIN_BYTES-1:0] win_hit, pol_we, enab_we;
  logic                 ctl_we, unused_hit;
  logic [LINES-1:0]     pin_sync;

  // Address decode
  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_pdec
    assign port_we[k] = wr_en_i && (addr_i == ADDR_W'(k));
  end

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_wdec
    assign win_hit[b]      = (addr_i == ADDR_W'(WIN_OFF + b));
    assign pol_we[b]       = wr_en_i && win_hit[b] && (page == PG_POL);
    assign enab_we[b]      = wr_en_i && win_hit[b] && (page == PG_ENAB);
    assign int_id_clr_o[b] = wr_en_i && win_hit[b] && (page == PG_IRQID);
  end

  assign ctl_we     = wr_en_i && (addr_i == ADDR_W'(CTL_OFF));
  assign unused_hit = (32'(addr_i) >= WIN_OFF + WIN_BYTES);

  gpio_pg_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_pg_ports #(.NUM_PORTS(NUM_PORTS)) u_ports (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (port_we),
    .lock_i  (lock),
    .wdata_i (wdata_i),
    .latch_o (pin_oe_o)
  );

  gpio_pg_paged #(.NUM_PORTS(NUM_PORTS), .WIN_BYTES(WIN_BYTES)) u_paged (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_we_i  (ctl_we),
    .pol_we_i  (pol_we),
    .enab_we_i (enab_we),
    .wdata_i   (wdata_i),
    .page_o    (page),
    .lock_o    (lock),
    .pol_o     (pol_o),
    .enab_o    (enab_o)
  );

  // Read mux; port reads return the inverted pin level
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_PORTS; k++)
      if (addr_i == ADDR_W'(k)) rdata_o = ~pin_sync[k*BW +: BW];
    if (addr_i == ADDR_W'(PEND_OFF)) rdata_o = int_pend_i;
    if (addr_i == ADDR_W'(CTL_OFF))  rdata_o = {page, lock};
    for (int b = 0; b < WIN_BYTES; b++)
      if (win_hit[b]) begin
        case (page)
          PG_POL:   rdata_o = pol_o[b*BW +: BW];
          PG_ENAB:  rdata_o = enab_o[b*BW +: BW];
          PG_IRQID: rdata_o = int_id_i[b*BW +: BW];
          default:  rdata_o = '0;
        endcase
      end
  end

  assert_bank_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|pol_we, |enab_we, |int_id_clr_o}));
  assert_clr_page_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_id_clr_o != '0) |-> (page == PG_IRQID && wr_en_i));
  assert_unused_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && unused_hit) |=> ($stable(pol_o) && $stable(enab_o) && $stable(pin_oe_o)));
  assert_page0_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (win_hit != '0) && page == PG_NONE) |=> ($stable(pol_o) && $stable(enab_o)));
endmodule

// File: tb/gpio_pg_regif_bench.sv
module gpio_pg_regif_bench;
  localparam int OP_W = 0, OP_R = 1, OP_O = 2;
  localparam int NV = 31;
  // {op[1:0], addr[3:0], data[7:0], expect[7:0]}
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 4'h0, 8'hA5, 8'h00},  // R2
    {2'd1, 4'h0, 8'h00, 8'hA5},  // R2 R3
    {2'd2, 4'h0, 8'h00, 8'hA5},  // R2
    {2'd0, 4'h5, 8'h3C, 8'h00},
    {2'd1, 4'h5, 8'h00, 8'h3C},
    {2'd2, 4'h5, 8'h00, 8'h3C},
    {2'd0, 4'h7, 8'h01, 8'h00},  // R5 lock port 0
    {2'd1, 4'h7, 8'h00, 8'h01},
    {2'd0, 4'h0, 8'hFF, 8'h00},  // R6
    {2'd1, 4'h0, 8'h00, 8'hA5},
    {2'd2, 4'h0, 8'h00, 8'hA5},
    {2'd0, 4'h1, 8'h0F, 8'h00},  // R6 other port
    {2'd1, 4'h1, 8'h00, 8'h0F},
    {2'd0, 4'h7, 8'h40, 8'h00},  // R7 page 1
    {2'd0, 4'h8, 8'h11, 8'h00},
    {2'd0, 4'h9, 8'h22, 8'h00},
    {2'd0, 4'hA, 8'h33, 8'h00},
    {2'd1, 4'h8, 8'h00, 8'h11},
    {2'd1, 4'hA, 8'h00, 8'h33},
    {2'd0, 4'h7, 8'h80, 8'h00},  // R7 page 2
    {2'd1, 4'h8, 8'h00, 8'h00},
    {2'd0, 4'h9, 8'h77, 8'h00},
    {2'd1, 4'h9, 8'h00, 8'h77},
    {2'd0, 4'h7, 8'h40, 8'h00},
    {2'd1, 4'h9, 8'h00, 8'h22},  // R7 pol kept
    {2'd0, 4'h7, 8'h00, 8'h00},  // R9 page 0
    {2'd1, 4'h8, 8'h00, 8'h00},
    {2'd0, 4'h8, 8'hEE, 8'h00},
    {2'd0, 4'hB, 8'h55, 8'h00},
    {2'd1, 4'hB, 8'h00, 8'h00},  // R9
    {2'd0, 4'h7, 8'hC0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [47:0] ext_lvl = '1;
  logic [47:0] pin, pin_oe;
  logic [7:0]  int_pend = '0;
  logic [23:0] int_id = '0;
  logic [2:0]  id_clr;
  logic [23:0] pol, enab;
  int          n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;
  assign pin = ext_lvl & ~pin_oe;  // open-drain board model

  gpio_pg_regif u_gpio_pg_regif (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_oe_o(pin_oe), .int_pend_i(int_pend),
    .int_id_i(int_id), .int_id_clr_o(id_clr), .pol_o(pol), .enab_o(enab)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 oe", 32'(pin_oe), 0);
    chk("R1 pol", 32'(pol), 0);
    chk("R1 enab", 32'(enab), 0);
    rd(4'h7, r); chk("R1 ctl", 32'(r), 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op; logic [3:0] a; logic [7:0] d, e;
      {op, a, d, e} = VEC[i];
      if (op == 2'(OP_W)) wr(a, d);
      else if (op == 2'(OP_R)) begin rd(a, r); chk("R7/R2/R3/R5/R6/R9 read", 32'(r), 32'(e)); end
      else if (op == 2'(OP_O)) chk("R2 oe", 32'(pin_oe[a*8 +: 8]), 32'(e));
    end

    // Page 3 selected by last vector
    rd(4'h0, r); chk("R10 port any page", 32'(r), 32'hA5);
    int_pend = 8'h05;
    rd(4'h6, r); chk("R10 pending p3", 32'(r), 32'h05);
    chk("R7 pol out", 32'(pol), 32'h332211);
    chk("R7 enab out", 32'(enab), 32'h007700);
    int_id = 24'h123456;
    rd(4'h8, r); chk("R8 id b0", 32'(r), 32'h56);
    rd(4'hA, r); chk("R8 id b2", 32'(r), 32'h12);
    @(negedge clk); addr = 4'h9; wdata = 8'hFF; wr_en = 1'b1; #1;
    chk("R8 clr strobe", 32'(id_clr), 32'b010);
    @(negedge clk); wr_en = 1'b0; #1;
    chk("R8 clr idle", 32'(id_clr), 0);
    chk("R8 no bank change", 32'({pol, enab}), 48'h332211_007700);
    wr(4'h7, 8'h40);
    @(negedge clk); addr = 4'h9; wdata = 8'h22; wr_en = 1'b1; #1;
    chk("R8 no strobe p1", 32'(id_clr), 0);
    @(negedge clk); wr_en = 1'b0;
    wr(4'h7, 8'h00);
    rd(4'h6, r); chk("R10 pending p0", 32'(r), 32'h05);
    rd(4'hF, r); chk("R9 top offset", 32'(r), 0);

    // Sync latency: port 2 latch clear, pins pulled low externally
    rd(4'h2, r); chk("R3 released reads 0", 32'(r), 0);
    @(negedge clk); ext_lvl[23:16] = 8'h5A; addr = 4'h2;
    @(negedge clk); #1 chk("R4 one edge old", 32'(rdata), 0);
    @(negedge clk); #1 chk("R4 two edges new R3", 32'(rdata), 32'hA5);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule